// File: doc/BRIEF.md
# Prescaled Free-Running Timer with Input Capture

This block is a 16-bit free-running counter that advances from the bus clock through a power-of-two pre-divider. When the counter wraps from its maximum value to zero, the block sets an overflow flag. If the overflow interrupt is enabled, the block raises an overflow request.

Three capture strobes each copy the live count into a capture register for that channel. Each strobe also sets a capture flag, and the capture flags can raise a second request through a capture mask.

Software uses a byte-wide register port. It reads the counter as two bytes, reads the captured values, and sets the enables. It clears flags by writing ones to them. The division ratio can be set only in a short window after reset and is locked after that window.

Top module: `tmr_top`

## Requirements
- R1: After reset the counter, the low-byte holding latch, all capture registers, all flags, the capture mask and the control register are zero, the ratio is divide by 1, and both requests are low.
- R2: The 2-bit ratio select in control bits 1:0 picks the divider: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 16. The counter advances by one on exactly those clock edges where the number of edges since reset release, taken modulo the ratio, equals the ratio minus one. The first edge after release is number 0.
- R3: A write to the control register (address 10) updates the ratio select only on edges numbered below 64. A later write keeps the previous select, while bit 7 (the overflow enable) still takes the written value.
- R4: The overflow flag (bit 7 of address 11) is set on the edge where the counter steps from 0xFFFF to 0x0000.
- R5: `ovf_irq_o` equals the AND of the overflow flag and the overflow enable, as they stood one clock earlier.
- R6: A strobe on `cap_stb_i` bit 2, 1 or 0 (channels 1, 2 and 3) latches the count held before that edge into the channel's register. Channel 1 reads at 2 (high) and 3 (low), channel 2 at 4 and 5, and channel 3 at 6 and 7. The strobe also sets the same bit of the capture flag register (address 9).
- R7: Writing address 9 or 11 clears only the flag bits written as 1. Bits written as 0 stay unchanged, and a flag that is set and cleared on the same edge ends up set.
- R8: Reading address 0 returns the counter's high byte and copies its low byte into a holding latch. Reading address 1 returns the latch, so the pair reads back as one 16-bit value.
- R9: `cap_irq_o` is high when any capture flag is set whose bit in the capture mask (address 8, bits 2:0) is also set, judged one clock earlier.
- R10: Read data appears on `rd_data_o` in the cycle after the read strobe. The control register reads back as {enable, 5'b0, select}, and the overflow flag register reads back as {flag, 7'b0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Registered read data |
| cap_stb_i | input | 3 | Capture strobes: bit 2 is channel 1, bit 0 is channel 3 |
| ovf_irq_o | output | 1 | Overflow interrupt request |
| cap_irq_o | output | 1 | Capture interrupt request |

## Verification
The overflow flag and its request are the hardest to reach. They need the counter to run through its full 16-bit range: 65536 edges at divide by 1, or far more at the larger ratios.

To get there, the stimulus first uses the 64-edge window to step through every ratio and then tries a late change of the ratio. It then resets the block and leaves the ratio at divide by 1, waits for the wrap, and watches the request appear one clock after the flag. It then clears the flag with a mix of zero and one bits.

Capture strobes are issued at random times and with random channel sets. Each captured value is compared with a count that the bench tracks edge by edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int N_CAP  = 3;
    localparam int SEL_W  = 2;
    localparam int PRE_W  = 4;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CNT_HI   = 4'd0,
        A_CNT_LO   = 4'd1,
        A_CAP1_HI  = 4'd2,
        A_CAP1_LO  = 4'd3,
        A_CAP2_HI  = 4'd4,
        A_CAP2_LO  = 4'd5,
        A_CAP3_HI  = 4'd6,
        A_CAP3_LO  = 4'd7,
        A_CAP_MASK = 4'd8,
        A_CAP_FLAG = 4'd9,
        A_CTL      = 4'd10,
        A_OVF_FLAG = 4'd11
    } reg_addr_e;

    typedef struct packed {
        logic             ovf_en;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    // low bits of the pre-divider that must all be one for a count step
    function automatic logic [PRE_W-1:0] div_mask(input logic [SEL_W-1:0] sel);
        case (sel)
            2'd0:    div_mask = 4'h0;
            2'd1:    div_mask = 4'h3;
            2'd2:    div_mask = 4'h7;
            default: div_mask = 4'hF;
        endcase
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int PW = PRE_W,
    parameter int SW = SEL_W
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [SW-1:0] sel_i,
    output logic          tick_o
);
    logic [PW-1:0] pre_q;
    logic [PW-1:0] msk;

    always_ff @(posedge clk_i) begin
        if (rst_i) pre_q <= '0;
        else       pre_q <= pre_q + 1'b1;
    end

    always_comb begin
        msk    = PW'(div_mask(sel_i));
        tick_o = (pre_q & msk) == msk;
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         tick_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)       cnt_q <= '0;
        else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = tick_i && (&cnt_q);
endmodule

// File: rtl/tmr_capture_bank.sv
module tmr_capture_bank #(
    parameter int W = 16,
    parameter int N = 3
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [N-1:0]        stb_i,
    input  logic [W-1:0]        cnt_i,
    output logic [N-1:0][W-1:0] val_o
);
    for (genvar g = 0; g < N; g++) begin : g_ch
        logic [W-1:0] hold_q;
        always_ff @(posedge clk_i) begin
            if (rst_i)         hold_q <= '0;
            else if (stb_i[g]) hold_q <= cnt_i;
        end
        assign val_o[g] = hold_q;
    end
endmodule

// File: rtl/tmr_top.sv
module tmr_top
    import tmr_pkg::*;
#(
    parameter int LOCK_CYCLES = 64
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [BYTE_W-1:0] rd_data_o,
    input  logic [N_CAP-1:0]  cap_stb_i,
    output logic              ovf_irq_o,
    output logic              cap_irq_o
);
    localparam int AGE_W = $clog2(LOCK_CYCLES + 1);

    logic [AGE_W-1:0]            age_q;
    logic                        sel_open;
    ctl_t                        ctl_q, ctl_d;
    logic [N_CAP-1:0]            cap_mask_q, cap_flag_q, cap_flag_d, cap_clr;
    logic                        ovf_flag_q, ovf_flag_d, ovf_clr;
    logic [BYTE_W-1:0]           lo_hold_q, rd_data_q, rd_mux;
    logic                        ovf_irq_q, cap_irq_q;
    logic                        tick, wrap;
    logic [CNT_W-1:0]            cnt_q;
    logic [N_CAP-1:0][CNT_W-1:0] cap_val;

    tmr_prescaler #(.PW(PRE_W), .SW(SEL_W)) u_pre (
        .clk_i(clk_i), .rst_i(rst_i), .sel_i(ctl_q.sel), .tick_o(tick));

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick), .cnt_o(cnt_q), .wrap_o(wrap));

    tmr_capture_bank #(.W(CNT_W), .N(N_CAP)) u_cap (
        .clk_i(clk_i), .rst_i(rst_i), .stb_i(cap_stb_i), .cnt_i(cnt_q), .val_o(cap_val));

    assign sel_open = age_q < AGE_W'(LOCK_CYCLES);

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en_i && addr_i == A_CTL) begin
            ctl_d.ovf_en = wr_data_i[BYTE_W-1];
            ctl_d.sel    = sel_open ? wr_data_i[SEL_W-1:0] : ctl_q.sel;
        end
        cap_clr    = (wr_en_i && addr_i == A_CAP_FLAG) ? wr_data_i[N_CAP-1:0] : '0;
        ovf_clr    = wr_en_i && addr_i == A_OVF_FLAG && wr_data_i[BYTE_W-1];
        cap_flag_d = (cap_flag_q & ~cap_clr) | cap_stb_i;
        ovf_flag_d = (ovf_flag_q & ~ovf_clr) | wrap;
    end

    always_comb begin
        rd_mux = '0;
        case (reg_addr_e'(addr_i))
            A_CNT_HI:   rd_mux = cnt_q[CNT_W-1 -: BYTE_W];
            A_CNT_LO:   rd_mux = lo_hold_q;
            A_CAP_MASK: rd_mux = BYTE_W'(cap_mask_q);
            A_CAP_FLAG: rd_mux = BYTE_W'(cap_flag_q);
            A_CTL:      rd_mux = {ctl_q.ovf_en, {(BYTE_W-1-SEL_W){1'b0}}, ctl_q.sel};
            A_OVF_FLAG: rd_mux = {ovf_flag_q, {(BYTE_W-1){1'b0}}};
            default:    rd_mux = '0;
        endcase
        for (int c = 0; c < N_CAP; c++) begin
            if (addr_i[ADDR_W-1:1] == (ADDR_W-1)'(c + 1))
                rd_mux = addr_i[0] ? cap_val[N_CAP-1-c][BYTE_W-1:0]
                                   : cap_val[N_CAP-1-c][CNT_W-1 -: BYTE_W];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            age_q      <= '0;
            ctl_q      <= '0;
            cap_mask_q <= '0;
            cap_flag_q <= '0;
            ovf_flag_q <= 1'b0;
            lo_hold_q  <= '0;
            rd_data_q  <= '0;
            ovf_irq_q  <= 1'b0;
            cap_irq_q  <= 1'b0;
        end else begin
            if (sel_open) age_q <= age_q + 1'b1;
            ctl_q      <= ctl_d;
            cap_flag_q <= cap_flag_d;
            ovf_flag_q <= ovf_flag_d;
            if (wr_en_i && addr_i == A_CAP_MASK) cap_mask_q <= wr_data_i[N_CAP-1:0];
            if (rd_en_i) begin
                rd_data_q <= rd_mux;
                if (addr_i == A_CNT_HI) lo_hold_q <= cnt_q[BYTE_W-1:0];
            end
            ovf_irq_q <= ovf_flag_q & ctl_q.ovf_en;
            cap_irq_q <= |(cap_flag_q & cap_mask_q);
        end
    end

    assign rd_data_o = rd_data_q;
    assign ovf_irq_o = ovf_irq_q;
    assign cap_irq_o = cap_irq_q;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int LOCK = 64,
    parameter int AW   = 7
) (
    input logic                        clk_i,
    input logic                        rst_i,
    input logic                        tick,
    input logic                        wrap,
    input logic [CNT_W-1:0]            cnt,
    input logic [SEL_W-1:0]            sel,
    input logic [AW-1:0]               age,
    input logic                        ovf_flag,
    input logic                        ovf_en,
    input logic                        ovf_irq,
    input logic [N_CAP-1:0]            cap_stb,
    input logic [N_CAP-1:0]            cap_flag,
    input logic [N_CAP-1:0]            cap_mask,
    input logic                        cap_irq,
    input logic [N_CAP-1:0][CNT_W-1:0] cap_val,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           addr,
    input logic [BYTE_W-1:0]           wr_data
);
    a_r2_count_step: assert property (@(posedge clk_i) disable iff (rst_i)
        tick |=> cnt == CNT_W'($past(cnt) + 1'b1));
    a_r2_count_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick |=> $stable(cnt));
    a_r3_sel_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        (age >= AW'(LOCK)) |=> $stable(sel));
    a_r4_wrap_flag: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap |=> ovf_flag);
    a_r5_ovf_irq: assert property (@(posedge clk_i) disable iff (rst_i)
        ovf_irq |-> $past(ovf_flag && ovf_en));
    a_r7_ovf_keep: assert property (@(posedge clk_i) disable iff (rst_i)
        (ovf_flag && !(wr_en && addr == A_OVF_FLAG && wr_data[BYTE_W-1])) |=> ovf_flag);
    a_r9_cap_irq: assert property (@(posedge clk_i) disable iff (rst_i)
        cap_irq |-> $past(|(cap_flag & cap_mask)));
    for (genvar g = 0; g < N_CAP; g++) begin : g_cap
        a_r6_capture: assert property (@(posedge clk_i) disable iff (rst_i)
            cap_stb[g] |=> (cap_flag[g] && cap_val[g] == $past(cnt)));
    end
endmodule

bind tmr_top tmr_chk #(.LOCK(LOCK_CYCLES), .AW(AGE_W)) chk_i (
    .clk_i(clk_i), .rst_i(rst_i), .tick(tick), .wrap(wrap), .cnt(cnt_q),
    .sel(ctl_q.sel), .age(age_q), .ovf_flag(ovf_flag_q), .ovf_en(ctl_q.ovf_en),
    .ovf_irq(ovf_irq_o), .cap_stb(cap_stb_i), .cap_flag(cap_flag_q),
    .cap_mask(cap_mask_q), .cap_irq(cap_irq_o), .cap_val(cap_val),
    .wr_en(wr_en_i), .addr(addr_i), .wr_data(wr_data_i));

// File: tb/tmr_top_tb_top.sv
module tmr_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [2:0] cap_stb = '0;
    logic       ovf_irq, cap_irq;

    int total = 0;
    int bad = 0;

    // bench model state
    int          e;
    logic [1:0]  msel;
    logic [15:0] cnt_m, snap_m;
    logic [15:0] cap_m [3];
    int          ovf_events;

    tmr_top dut_i (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_data_o(rd_data), .cap_stb_i(cap_stb),
        .ovf_irq_o(ovf_irq), .cap_irq_o(cap_irq));

    always #4 clk = ~clk;

    function automatic int ratio_of(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 16;
        endcase
    endfunction

    // R2/R3/R4/R6/R8 reference model; inputs change only at falling edges
    always @(posedge clk) begin
        if (rst) begin
            e = 0; msel = 2'd0; cnt_m = '0; snap_m = '0; ovf_events = 0;
            for (int i = 0; i < 3; i++) cap_m[i] = '0;
        end else begin
            if (rd_en && addr == 4'd0) snap_m = cnt_m;
            for (int b = 0; b < 3; b++) if (cap_stb[b]) cap_m[b] = cnt_m;
            if ((e % ratio_of(msel)) == ratio_of(msel) - 1) begin
                if (cnt_m == 16'hFFFF) ovf_events++;
                cnt_m = cnt_m + 16'd1;
            end
            if (wr_en && addr == 4'd10 && e < 64) msel = wr_data[1:0];
            e++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic check_count(input string req);
        logic [7:0] hi, lo;
        rd(4'd0, hi);
        repeat (3) @(negedge clk);
        rd(4'd1, lo);
        check(req, {hi, lo}, snap_m);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [2:0] s;
        logic [2:0] flag_m;
        void'($urandom(32'd4242));
        flag_m = '0;

        // ---- phase A: reset state, ratios, lock window, captures
        do_reset();
        rd(4'd10, d);  check("R1 ctl", d, 0);
        rd(4'd11, d);  check("R1 ovf flag", d, 0);
        rd(4'd9, d);   check("R1 cap flag", d, 0);
        check("R1 irqs", {ovf_irq, cap_irq}, 0);
        rd(4'd2, d);   check("R1 capture reg", d, 0);
        check_count("R8 count at divide by 1");
        wr(4'd10, 8'h02);
        repeat (6) @(negedge clk);
        check_count("R2 count at divide by 8");
        wr(4'd10, 8'h03);
        repeat (5) @(negedge clk);
        check_count("R2 count at divide by 16");
        wr(4'd10, 8'h01);
        rd(4'd10, d);  check("R10 ctl readback", d, 8'h01);
        repeat (40) @(negedge clk);
        wr(4'd10, 8'h83);
        rd(4'd10, d);  check("R3 late select ignored, enable kept", d, 8'h81);
        check("R3 ratio held", ratio_of(msel), 4);
        for (int k = 0; k < 4; k++) begin
            repeat ($urandom_range(1, 40)) @(negedge clk);
            check_count("R2 count at divide by 4");
        end
        check("R5 no request without overflow", ovf_irq, 0);

        for (int k = 0; k < 16; k++) begin
            s = 3'($urandom_range(1, 7));
            repeat ($urandom_range(0, 20)) @(negedge clk);
            @(negedge clk); cap_stb = s;
            @(negedge clk); cap_stb = '0;
            flag_m = flag_m | s;
            for (int b = 0; b < 3; b++) begin
                if (s[b]) begin
                    logic [7:0] hi, lo;
                    rd(4'(2 + 2 * (2 - b)), hi);
                    rd(4'(3 + 2 * (2 - b)), lo);
                    check("R6 captured value", {hi, lo}, cap_m[b]);
                end
            end
            rd(4'd9, d); check("R6 capture flags", d, flag_m);
        end
        flag_m = 3'b111;
        @(negedge clk); cap_stb = 3'b111;
        @(negedge clk); cap_stb = '0;
        wr(4'd9, 8'h00);
        rd(4'd9, d);   check("R7 zero write keeps flags", d, 8'h07);
        wr(4'd9, 8'h02);
        rd(4'd9, d);   check("R7 partial clear", d, 8'h05);
        wr(4'd8, 8'h02);
        repeat (2) @(negedge clk);
        check("R9 masked flag no request", cap_irq, 0);
        wr(4'd8, 8'h01);
        repeat (2) @(negedge clk);
        check("R9 request on enabled flag", cap_irq, 1);
        @(negedge clk); cap_stb = 3'b001; addr = 4'd9; wr_data = 8'h01; wr_en = 1'b1;
        @(negedge clk); cap_stb = '0; wr_en = 1'b0;
        rd(4'd9, d);   check("R7 set wins over clear", d, 8'h05);
        wr(4'd9, 8'h07);
        rd(4'd9, d);   check("R7 clear all", d, 0);
        repeat (2) @(negedge clk);
        check("R9 request drops", cap_irq, 0);

        // ---- phase B: reset again, divide by 1, run to the wrap
        do_reset();
        rd(4'd10, d);  check("R1 ctl after second reset", d, 0);
        wr(4'd10, 8'h80);
        while (cnt_m < 16'hFF00) @(negedge clk);
        check_count("R8 count near top");
        rd(4'd11, d);  check("R4 no flag before wrap", d, 0);
        while (ovf_events == 0) @(negedge clk);
        check("R5 request one clock after flag", ovf_irq, 0);
        @(negedge clk);
        check("R5 request raised", ovf_irq, 1);
        rd(4'd11, d);  check("R4 flag after wrap", d, 8'h80);
        check_count("R2 count after wrap");
        wr(4'd11, 8'h7F);
        rd(4'd11, d);  check("R7 zero bit keeps overflow flag", d, 8'h80);
        wr(4'd11, 8'h80);
        rd(4'd11, d);  check("R7 overflow flag cleared", d, 0);
        check("R5 request dropped", ovf_irq, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule